// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, for every incoming frame, whether the frame should be kept. The frame arrives one byte per cycle, marked by a start flag on the first byte and an end flag on the last byte. The byte stream handed to the block excludes the frame check sequence. The block captures the first six bytes as the destination address. While those bytes arrive, it also runs a CRC-32 over them and uses the result to look up a 64-bit multicast hash table. It counts the frame length up to the minimum frame size.

One cycle after the last byte, the block presents a verdict. The verdict carries an accept flag, a multicast-table hit flag and a runt flag. A host programs the station address, the hash table and a receive-control register through a simple byte-wide write port. In monitor mode, every frame is judged but refused, and each judged frame advances a missed-frame counter.

The control is a four-state machine:

- `ST_IDLE` waits for a start byte.
- `ST_ADDR` collects the six address bytes.
- `ST_BODY` counts the remaining bytes.
- `ST_VERDICT` presents the result for exactly one cycle.

Its transitions are:

- *start*: any state goes to `ST_ADDR` on a byte flagged as the start, or to `ST_VERDICT` if that byte is also flagged as the end.
- *addr_full*: `ST_ADDR` goes to `ST_BODY` on the sixth byte.
- *frame_end*: `ST_ADDR` or `ST_BODY` goes to `ST_VERDICT` on the end byte.
- *release*: `ST_VERDICT` goes to `ST_IDLE`.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, all host registers are zero, `verdict_valid`, `accept`, `mcast_hit` and `runt` are low, and `missed_count` is zero. With all-zero registers, a unicast frame whose destination differs from zero is refused.
- R2: The host write map is as follows:
  - address k (0 to 5) holds station byte k, which is compared with the k-th destination byte received;
  - address 7 is receive control;
  - addresses 8 to 15 hold hash table register (address − 8);
  - a write to address 6 changes nothing.
- R3: `verdict_valid` is high for exactly one cycle, the cycle after the clock edge that captured a byte flagged `rx_eof` inside a frame. `accept`, `mcast_hit` and `runt` are low in every other cycle.
- R4: A unicast destination (bit 0 of the first byte clear) is accepted when it equals the station address, or when the promiscuous bit (control bit 4) is set.
- R5: The all-ones destination is accepted only when the broadcast bit (control bit 2) is set. The promiscuous bit alone does not admit it.
- R6: The multicast hash works as follows:
  - the CRC register is preset to all ones;
  - each destination byte is folded in least significant bit first, with the reflected polynomial 0xEDB88320 and no final inversion;
  - the hash index has bit (5−k) equal to CRC bit k, for k = 0..5;
  - index i selects table register i/8, bit i%8.
- R7: For a multicast destination (first-byte bit 0 set, not all ones), `mcast_hit` reports the indexed table bit. The frame is accepted only when that bit is 1 and the multicast bit (control bit 3) is set.
- R8: A frame shorter than 60 bytes raises `runt` and is refused unless the runt bit (control bit 1) is set. A frame shorter than 6 bytes is always refused.
- R9: With the monitor bit (control bit 5) set, `accept` stays low, and `missed_count` advances by one for each verdict, wrapping modulo 256.
- R10: A start byte abandons any frame in progress without a verdict. Bytes presented outside a frame without a start flag are ignored.
- R11: A verdict uses the control, station and table values held in the verdict cycle. A host write or a new start byte in that same cycle affects only later frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| rx_valid | input | 1 | Receive byte present |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| verdict_valid | output | 1 | Verdict present this cycle |
| accept | output | 1 | Frame is to be kept |
| mcast_hit | output | 1 | Multicast destination hit a set table bit |
| runt | output | 1 | Frame shorter than the minimum |
| missed_count | output | 8 | Frames judged in monitor mode |

## Verification
The delicate overlap is a verdict cycle that also carries the start byte of the next frame and a host write to receive control. The bench provokes it by driving a broadcast frame immediately after another broadcast frame. The new frame's first byte comes together with a write that clears the broadcast bit. The earlier frame must still be accepted under the old setting, the later one refused, and no extra or missing verdict may appear in between.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_BODY,
        ST_VERDICT
    } rxf_state_e;

    localparam int HA_W       = 4;
    localparam int RC_RUNT    = 1;
    localparam int RC_BCAST   = 2;
    localparam int RC_MCAST   = 3;
    localparam int RC_PROMISC = 4;
    localparam int RC_MONITOR = 5;

    localparam logic [HA_W-1:0] HA_CTRL = 4'd7;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    // Fold one byte into a reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int TBL_REGS   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [HA_W-1:0]              addr,
    input  logic [7:0]                   wdata,
    output logic [ADDR_BYTES-1:0][7:0]   station,
    output logic [RC_MONITOR:RC_RUNT]    rcfg,
    output logic [TBL_REGS*8-1:0]        table_bits
);

    localparam int TBL_BASE = 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            station <= '0;
        end else if (we) begin
            for (int k = 0; k < ADDR_BYTES; k++) begin
                if (addr == HA_W'(k)) station[k] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcfg <= '0;
        end else if (we && addr == HA_CTRL) begin
            rcfg <= wdata[RC_MONITOR:RC_RUNT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            table_bits <= '0;
        end else if (we) begin
            for (int t = 0; t < TBL_REGS; t++) begin
                if (addr == HA_W'(TBL_BASE + t)) table_bits[8*t +: 8] <= wdata;
            end
        end
    end

endmodule

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash
    import rxf_pkg::*;
#(
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seed,
    input  logic                 adv,
    input  logic [7:0]           din,
    output logic [HASH_BITS-1:0] idx
);

    logic [31:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (seed) begin
            crc_q <= crc_byte('1, din);
        end else if (adv) begin
            crc_q <= crc_byte(crc_q, din);
        end
    end

    // Index is the low CRC bits taken in reversed order.
    for (genvar k = 0; k < HASH_BITS; k++) begin : g_rev
        assign idx[HASH_BITS-1-k] = crc_q[k];
    end

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide #(
    parameter int ADDR_BYTES = 6,
    parameter int MIN_LEN    = 60,
    parameter int CNT_W      = 6,
    parameter int HASH_BITS  = 6
) (
    input  logic                        in_verdict,
    input  logic [ADDR_BYTES-1:0][7:0]  dst,
    input  logic [ADDR_BYTES-1:0][7:0]  station,
    input  logic [(1<<HASH_BITS)-1:0]   table_bits,
    input  logic [HASH_BITS-1:0]        idx,
    input  logic [CNT_W-1:0]            cnt,
    input  logic                        en_runt,
    input  logic                        en_bcast,
    input  logic                        en_mcast,
    input  logic                        en_promisc,
    input  logic                        en_monitor,
    output logic                        accept,
    output logic                        mcast_hit,
    output logic                        runt
);

    logic complete, is_bcast, is_mcast, tbl_hit, addr_ok, len_ok, short_frame;

    always_comb begin
        complete    = cnt >= CNT_W'(ADDR_BYTES);
        short_frame = cnt <  CNT_W'(MIN_LEN);
        is_bcast    = &dst;
        is_mcast    = dst[0][0] && !is_bcast;
        tbl_hit     = table_bits[idx];
        if (is_bcast)      addr_ok = en_bcast;
        else if (is_mcast) addr_ok = en_mcast && tbl_hit;
        else               addr_ok = en_promisc || (dst == station);
        len_ok      = !short_frame || en_runt;

        accept    = in_verdict && complete && addr_ok && len_ok && !en_monitor;
        mcast_hit = in_verdict && complete && is_mcast && tbl_hit;
        runt      = in_verdict && short_frame;
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int MIN_LEN = 60,
    parameter int MISS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [3:0]        host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    output logic              verdict_valid,
    output logic              accept,
    output logic              mcast_hit,
    output logic              runt,
    output logic [MISS_W-1:0] missed_count
);

    localparam int ADDR_BYTES = 6;
    localparam int HASH_BITS  = 6;
    localparam int TBL_REGS   = (1 << HASH_BITS) / 8;
    localparam int CNT_W      = $clog2(MIN_LEN + 1);

    rxf_state_e                 state_q, state_d;
    logic [CNT_W-1:0]           byte_cnt;
    logic [ADDR_BYTES-1:0][7:0] dst;
    logic [ADDR_BYTES-1:0][7:0] station;
    logic [RC_MONITOR:RC_RUNT]  rcfg;
    logic [TBL_REGS*8-1:0]      table_bits;
    logic [HASH_BITS-1:0]       hash_idx;
    logic                       first, take, in_verdict;

    assign first = rx_valid && rx_sof;
    assign take  = rx_valid && (rx_sof || state_q == ST_ADDR || state_q == ST_BODY);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (first) begin
            state_d = rx_eof ? ST_VERDICT : ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_ADDR: begin
                    if (rx_valid) begin
                        if (rx_eof)                                     state_d = ST_VERDICT;
                        else if (byte_cnt == CNT_W'(ADDR_BYTES - 1))    state_d = ST_BODY;
                    end
                end
                ST_BODY:    if (rx_valid && rx_eof) state_d = ST_VERDICT;
                ST_VERDICT: state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_verdict    = (state_q == ST_VERDICT);
        verdict_valid = in_verdict;
    end

    // Length counter, saturating at the minimum frame size
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          byte_cnt <= '0;
        else if (first)                                      byte_cnt <= CNT_W'(1);
        else if (take && byte_cnt != CNT_W'(MIN_LEN))        byte_cnt <= byte_cnt + 1'b1;
    end

    // Destination capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst <= '0;
        end else if (first) begin
            dst[0] <= rx_data;
        end else if (take) begin
            for (int g = 1; g < ADDR_BYTES; g++) begin
                if (byte_cnt == CNT_W'(g)) dst[g] <= rx_data;
            end
        end
    end

    // Missed-frame counter for monitor mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              missed_count <= '0;
        else if (in_verdict && rcfg[RC_MONITOR]) missed_count <= missed_count + 1'b1;
    end

    rxf_cfg_regs #(
        .ADDR_BYTES (ADDR_BYTES),
        .TBL_REGS   (TBL_REGS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (host_we),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .station    (station),
        .rcfg       (rcfg),
        .table_bits (table_bits)
    );

    rxf_crc_hash #(
        .HASH_BITS (HASH_BITS)
    ) u_hash (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (first),
        .adv   (take && !rx_sof && byte_cnt < CNT_W'(ADDR_BYTES)),
        .din   (rx_data),
        .idx   (hash_idx)
    );

    rxf_decide #(
        .ADDR_BYTES (ADDR_BYTES),
        .MIN_LEN    (MIN_LEN),
        .CNT_W      (CNT_W),
        .HASH_BITS  (HASH_BITS)
    ) u_decide (
        .in_verdict (in_verdict),
        .dst        (dst),
        .station    (station),
        .table_bits (table_bits),
        .idx        (hash_idx),
        .cnt        (byte_cnt),
        .en_runt    (rcfg[RC_RUNT]),
        .en_bcast   (rcfg[RC_BCAST]),
        .en_mcast   (rcfg[RC_MCAST]),
        .en_promisc (rcfg[RC_PROMISC]),
        .en_monitor (rcfg[RC_MONITOR]),
        .accept     (accept),
        .mcast_hit  (mcast_hit),
        .runt       (runt)
    );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int MISS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_eof,
    input logic              verdict_valid,
    input logic              accept,
    input logic              mcast_hit,
    input logic              runt,
    input logic [5:1]        rcfg,
    input logic [MISS_W-1:0] missed
);

    // R3: result flags stay low outside the verdict cycle
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !verdict_valid |-> (!accept && !mcast_hit && !runt));

    // R3: a verdict always follows an end byte
    a_r3_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> $past(rx_valid && rx_eof));

    // R7: a multicast acceptance requires the multicast control bit
    a_r7_mcast_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mcast_hit) |-> rcfg[3]);

    // R8: an accepted runt requires the runt control bit
    a_r8_runt_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && runt) |-> rcfg[1]);

    // R9: monitor mode refuses every frame
    a_r9_monitor_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && rcfg[5]) |-> !accept);

    // R9: each monitored verdict advances the counter by one
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && rcfg[5]) |=> (missed == $past(missed) + 1'b1));

    // R9: the counter holds otherwise
    a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(verdict_valid && rcfg[5]) |=> $stable(missed));

endmodule

bind rx_addr_filter rxf_checker #(.MISS_W(MISS_W)) u_rxf_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_eof        (rx_eof),
    .verdict_valid (verdict_valid),
    .accept        (accept),
    .mcast_hit     (mcast_hit),
    .runt          (runt),
    .rcfg          (rcfg),
    .missed        (missed_count)
);

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       rx_valid = 1'b0;
    logic       rx_sof = 1'b0;
    logic       rx_eof = 1'b0;
    logic [7:0] rx_data = '0;
    logic       verdict_valid, accept, mcast_hit, runt;
    logic [7:0] missed_count;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [47:0] sh_sta = '0;
    logic [7:0]  sh_cfg = '0;
    logic [63:0] sh_tbl = '0;

    typedef struct {
        int         due;
        logic [2:0] v;
        string      tag;
    } exp_t;
    exp_t sb[$];

    rx_addr_filter uut (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .verdict_valid(verdict_valid), .accept(accept), .mcast_hit(mcast_hit),
        .runt(runt), .missed_count(missed_count)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] hash_of(input logic [47:0] da);
        logic [31:0] c;
        logic        fb;
        logic [5:0]  ix;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            fb = c[0] ^ da[i];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        for (int k = 0; k < 6; k++) ix[5-k] = c[k];
        return ix;
    endfunction

    // Expected {accept, mcast_hit, runt} from the requirements
    function automatic logic [2:0] model(input logic [47:0] da, input int len);
        logic full, bc, mc, hit, ok, rn, acc;
        full = (len >= 6);
        bc   = (da == 48'hFFFF_FFFF_FFFF);
        mc   = da[0] && !bc;
        hit  = sh_tbl[hash_of(da)];
        rn   = (len < 60);
        if (bc)      ok = sh_cfg[2];
        else if (mc) ok = sh_cfg[3] && hit;
        else         ok = sh_cfg[4] || (da == sh_sta);
        acc  = full && ok && (!rn || sh_cfg[1]) && !sh_cfg[5];
        return {acc, full && mc && hit, rn};
    endfunction

    task automatic shadow_write(input logic [3:0] a, input logic [7:0] d);
        if (a < 4'd6)       sh_sta[8*a +: 8] = d;
        else if (a == 4'd7) sh_cfg = d;
        else if (a >= 4'd8) sh_tbl[8*(a-8) +: 8] = d;
    endtask

    task automatic hw(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        host_we = 1'b1; host_addr = a; host_wdata = d;
        shadow_write(a, d);
        @(posedge clk); #2;
        host_we = 1'b0;
    endtask

    task automatic drive_frame(input logic [47:0] da, input int len, input bit abort,
                               input bit wr, input logic [3:0] wa, input logic [7:0] wd,
                               input string tag);
        exp_t e;
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #2;
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = !abort && (i == len - 1);
            rx_data  = (i < 6) ? da[8*i +: 8] : 8'(8'hA0 + i);
            if (rx_eof) begin
                e.due = cyc + 1; e.v = model(da, len); e.tag = tag;
                sb.push_back(e);
            end
            if (i == 0 && wr) begin
                host_we = 1'b1; host_addr = wa; host_wdata = wd;
                shadow_write(wa, wd);
            end else begin
                host_we = 1'b0;
            end
        end
    endtask

    task automatic idle(input int n);
        @(posedge clk); #2;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; host_we = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    task automatic frame(input logic [47:0] da, input int len, input string tag);
        drive_frame(da, len, 1'b0, 1'b0, 4'd0, 8'd0, tag);
        idle(2);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                chk(verdict_valid == 1'b1, {sb[0].tag, " R3 verdict timing"}, 64'(verdict_valid), 64'd1);
                chk({accept, mcast_hit, runt} == sb[0].v, {sb[0].tag, " result"},
                    64'({accept, mcast_hit, runt}), 64'(sb[0].v));
                void'(sb.pop_front());
            end else begin
                chk({verdict_valid, accept, mcast_hit, runt} == 4'b0, "R3/R10 no verdict expected",
                    64'({verdict_valid, accept, mcast_hit, runt}), 64'd0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    localparam logic [47:0] STA   = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MCA   = {8'h01, 8'h00, 8'h00, 8'h5e, 8'h00, 8'h01};

    initial begin
        logic [5:0] mi;
        logic [7:0] m0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk({verdict_valid, accept, mcast_hit, runt} == 4'b0, "R1 reset outputs",
            64'({verdict_valid, accept, mcast_hit, runt}), 64'd0);
        chk(missed_count == 8'd0, "R1 reset counter", 64'(missed_count), 64'd0);

        frame(STA, 64, "R1 zero config refuses unicast");

        for (int k = 0; k < 6; k++) hw(4'(k), STA[8*k +: 8]);
        hw(4'd7, 8'h04);
        frame(STA, 64, "R2 R4 station match");
        frame({8'h56, STA[39:0]}, 64, "R2 R4 last byte differs");
        hw(4'd6, 8'hFF);
        frame(STA, 64, "R2 address 6 ignored");
        frame({8'h56, STA[39:0]}, 64, "R2 address 6 ignored mismatch");
        hw(4'd7, 8'h14);
        frame({8'h56, STA[39:0]}, 64, "R4 promiscuous unicast");

        hw(4'd7, 8'h04);
        frame(BCAST, 64, "R5 broadcast enabled");
        hw(4'd7, 8'h10);
        frame(BCAST, 64, "R5 promiscuous does not admit broadcast");
        hw(4'd7, 8'h00);
        frame(BCAST, 64, "R5 broadcast disabled");

        mi = hash_of(MCA);
        hw(4'd7, 8'h08);
        frame(MCA, 64, "R6 R7 table empty");
        hw(4'(8 + mi / 8), 8'(1 << (mi % 8)));
        frame(MCA, 64, "R6 R7 indexed bit set");
        hw(4'd7, 8'h00);
        frame(MCA, 64, "R7 hit but multicast disabled");
        hw(4'd7, 8'h08);
        hw(4'(8 + mi / 8), 8'(~(1 << (mi % 8))));
        frame(MCA, 64, "R6 R7 other bits only");

        hw(4'd7, 8'h04);
        frame(BCAST, 59, "R8 59 bytes runt");
        frame(BCAST, 60, "R8 60 bytes full");
        hw(4'd7, 8'h06);
        frame(BCAST, 59, "R8 runt accepted");
        frame(BCAST, 3, "R8 short address refused");
        frame(BCAST, 1, "R8 single byte refused");

        hw(4'd7, 8'h04);
        @(negedge clk);
        chk(missed_count == 8'd0, "R9 counter idle outside monitor", 64'(missed_count), 64'd0);
        hw(4'd7, 8'h24);
        frame(BCAST, 64, "R9 monitor refuses");
        @(negedge clk);
        chk(missed_count == 8'd1, "R9 counter after one", 64'(missed_count), 64'd1);
        m0 = missed_count;
        for (int f = 0; f < 256; f++) drive_frame(BCAST, 6, 1'b0, 1'b0, 4'd0, 8'd0, "R9 monitor burst");
        idle(2);
        @(negedge clk);
        chk(missed_count == m0, "R9 counter wraps", 64'(missed_count), 64'(m0));

        hw(4'd7, 8'h04);
        drive_frame(STA, 4, 1'b1, 1'b0, 4'd0, 8'd0, "R10 abandoned");
        frame(BCAST, 64, "R10 restart after abandon");
        @(posedge clk); #2;
        rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = 1'b1; rx_data = 8'h02;
        repeat (3) @(posedge clk);
        idle(2);
        frame(BCAST, 64, "R10 after stray bytes");

        drive_frame(BCAST, 64, 1'b0, 1'b0, 4'd0, 8'd0, "R11 old setting");
        drive_frame(BCAST, 64, 1'b0, 1'b1, 4'd7, 8'h00, "R11 new setting");
        idle(3);

        @(negedge clk);
        chk(sb.size() == 0, "R3 all verdicts seen", 64'(sb.size()), 64'd0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule